// File: doc/BRIEF.md
# Redundant-Radix Carry Normalizer

This block brings a multi-word integer held in redundant radix-2^D digits back into a tight form. Every XLEN-bit word stores D value bits plus R = XLEN − D headroom bits, and the integer is the sum of word i times 2^(i·D), with word 0 least significant. Arithmetic that runs without carry chains lets the headroom bits fill up, and this unit clears them again.

The operand is written one word at a time through a load port. A start request then runs one of two passes. The semi pass finishes in one cycle: each word keeps its own low D bits and takes the headroom of the word below it. The full pass moves one word per cycle, from word 0 upwards, and ripples a carry that can be seeded from a carry-in. Its output is canonical, and in signed operation the top word may keep an all-ones headroom field that stands for a negative value. The result words are read through an indexed read port, and the final carry appears on a separate output.

Top module: `rrn_carry_norm`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, every result word reads 0 and `carry_o` is 0.
- R2: With `ld_en_i` high, `ld_word_i` is written into operand slot `ld_idx_i`. The write is dropped while `busy_o` is high, and also in the cycle in which a start is accepted.
- R3: With `mode_i` = 0 (semi), result word 0 is operand word 0 masked to its low D bits. Result word i > 0 is (operand i masked to D bits) + (operand i−1 >> D). `carry_in_i` has no effect, and `done_o` is high in the cycle after the start edge.
- R4: After a semi pass, `carry_o` equals operand N−1 >> D. This is the excess that is dropped from the vector. With the default widths every result word is below 2^D + 2^R, so bits XLEN−1..D+1 are zero.
- R5: With `mode_i` = 1 (full) the pass starts from carry = `carry_in_i` and visits words 0..N−1 in order. At each word: carry += word, result = carry masked to D bits, carry >>= D. `carry_o` is the final carry.
- R6: A full pass keeps `busy_o` high for N cycles, and `done_o` rises exactly N clock edges after the start edge.
- R7: After an unsigned full pass, bits XLEN−1..D of every result word are zero.
- R8: With `signed_i` = 1 in full mode, operand N−1 is taken as two's complement. The top result word is the low XLEN bits of (carry + sign-extended word), so a negative total gives all-ones headroom bits. `carry_o` is that sum shifted right arithmetically by D, and lower words are unsigned and masked.
- R9: A start request while `busy_o` is high is ignored and does not disturb the running pass.
- R10: Result words and `carry_o` hold their values from `done_o` until the next accepted start. `rd_word_o` shows result word `rd_idx_i` combinationally.
- R11: `done_o` is high for a single cycle unless another start is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_en_i | input | 1 | Operand word write enable |
| ld_idx_i | input | IDXW | Operand word index |
| ld_word_i | input | XLEN | Operand word data |
| mode_i | input | 1 | 0 semi pass, 1 full pass |
| signed_i | input | 1 | Signed top word (full pass) |
| carry_in_i | input | XLEN | Carry seed for the full pass |
| start_i | input | 1 | Start request |
| busy_o | output | 1 | Full pass in progress |
| done_o | output | 1 | Pass finished |
| rd_idx_i | input | IDXW | Result word index |
| rd_word_o | output | XLEN | Selected result word |
| carry_o | output | XLEN+1 | Final carry of the last pass |

## Verification
An operand write and an accepted start can fall in the same clock edge, and so can a repeated start and a running ripple step. The bench provokes the first case by holding `ld_en_i` with a poison word while `start_i` is accepted. It provokes the second by pulsing `start_i` again with the other mode in the middle of a full pass. Both are judged at the ports. The results must match the reference model for the unpoisoned operand, the latency must stay at N cycles, and a later semi pass on the retained operand must again match the clean operand.

// File: rtl/rrn_pkg.sv
package rrn_pkg;
  typedef enum logic {
    MODE_SEMI = 1'b0,
    MODE_FULL = 1'b1
  } norm_mode_e;
endpackage

// File: rtl/rrn_operand_bank.sv
module rrn_operand_bank #(
  parameter int XLEN   = 32,
  parameter int NWORDS = 4,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lock_i,
  input  logic                     wr_en_i,
  input  logic [IDXW-1:0]          wr_idx_i,
  input  logic [XLEN-1:0]          wr_data_i,
  output logic [NWORDS*XLEN-1:0]   words_o
);
  logic [XLEN-1:0] mem_q [NWORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i && !lock_i && (int'(wr_idx_i) < NWORDS)) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_flat
    assign words_o[g*XLEN +: XLEN] = mem_q[g];
  end

  AST_LOAD_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(words_o)); // R2
endmodule

// File: rtl/rrn_semi_carry.sv
module rrn_semi_carry #(
  parameter int XLEN   = 32,
  parameter int DBITS  = 24,
  parameter int NWORDS = 4,
  localparam int RBITS = XLEN - DBITS
) (
  input  logic [NWORDS*XLEN-1:0] words_i,
  output logic [NWORDS*XLEN-1:0] words_o,
  output logic [RBITS-1:0]       excess_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [XLEN-1:0] own;
    assign own = {{RBITS{1'b0}}, words_i[g*XLEN +: DBITS]};
    if (g == 0) begin : g_low
      assign words_o[g*XLEN +: XLEN] = own;
    end else begin : g_up
      logic [XLEN-1:0] spill;
      assign spill = {{DBITS{1'b0}}, words_i[(g-1)*XLEN+DBITS +: RBITS]};
      assign words_o[g*XLEN +: XLEN] = own + spill;
    end
  end

  assign excess_o = words_i[(NWORDS-1)*XLEN+DBITS +: RBITS];
endmodule

// File: rtl/rrn_ripple_step.sv
module rrn_ripple_step #(
  parameter int XLEN  = 32,
  parameter int DBITS = 24,
  localparam int RBITS = XLEN - DBITS,
  localparam int SW    = XLEN + 2
) (
  input  logic [XLEN:0]   carry_i,
  input  logic [XLEN-1:0] word_i,
  input  logic            signed_top_i,
  output logic [XLEN-1:0] word_o,
  output logic [XLEN:0]   carry_o
);
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] shifted;

  always_comb begin
    if (signed_top_i) sum = $signed({1'b0, carry_i}) + $signed({{2{word_i[XLEN-1]}}, word_i});
    else              sum = $signed({1'b0, carry_i}) + $signed({2'b00, word_i});
  end

  // top word of a signed pass keeps its headroom bits as sign
  assign word_o  = signed_top_i ? sum[XLEN-1:0] : {{RBITS{1'b0}}, sum[DBITS-1:0]};
  assign shifted = sum >>> DBITS;
  assign carry_o = shifted[XLEN:0];
endmodule

// File: rtl/rrn_seq_ctrl.sv
module rrn_seq_ctrl #(
  parameter int NWORDS = 4,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            full_i,
  output logic            go_o,
  output logic            busy_o,
  output logic            last_o,
  output logic [IDXW-1:0] idx_o,
  output logic            done_o
);
  logic            busy_q, done_q;
  logic [IDXW-1:0] idx_q;

  assign go_o   = start_i && !busy_q;
  assign last_o = (idx_q == IDXW'(NWORDS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else if (go_o) begin
      busy_q <= full_i;
      done_q <= !full_i;
      idx_q  <= '0;
    end else if (busy_q) begin
      done_q <= last_o;
      if (last_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  AST_FULL_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && last_o |=> done_q && !busy_q); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !last_o |=> busy_q && (idx_q == IDXW'($past(idx_q) + 1'b1))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> !done_q); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q); // R6
endmodule

// File: rtl/rrn_carry_norm.sv
module rrn_carry_norm
  import rrn_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DBITS  = 24,
  parameter int NWORDS = 4,
  localparam int RBITS = XLEN - DBITS,
  localparam int IDXW  = $clog2(NWORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_en_i,
  input  logic [IDXW-1:0] ld_idx_i,
  input  logic [XLEN-1:0] ld_word_i,
  input  logic            mode_i,
  input  logic            signed_i,
  input  logic [XLEN-1:0] carry_in_i,
  input  logic            start_i,
  output logic            busy_o,
  output logic            done_o,
  input  logic [IDXW-1:0] rd_idx_i,
  output logic [XLEN-1:0] rd_word_o,
  output logic [XLEN:0]   carry_o
);
  logic [NWORDS*XLEN-1:0] opnd, semi_w, res_flat;
  logic [RBITS-1:0]       semi_excess;
  logic                   go, busy, last;
  logic [IDXW-1:0]        idx;
  logic [XLEN-1:0]        step_word;
  logic [XLEN:0]          step_carry;
  norm_mode_e             mode_q;
  logic                   sgn_q;
  logic [XLEN:0]          run_c_q, carry_q;
  logic [XLEN-1:0]        res_q [NWORDS];

  rrn_seq_ctrl #(.NWORDS(NWORDS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .full_i(mode_i),
    .go_o(go), .busy_o(busy), .last_o(last), .idx_o(idx), .done_o
  );

  rrn_operand_bank #(.XLEN(XLEN), .NWORDS(NWORDS)) u_bank (
    .clk_i, .rst_ni, .lock_i(busy | go),
    .wr_en_i(ld_en_i), .wr_idx_i(ld_idx_i), .wr_data_i(ld_word_i), .words_o(opnd)
  );

  rrn_semi_carry #(.XLEN(XLEN), .DBITS(DBITS), .NWORDS(NWORDS)) u_semi (
    .words_i(opnd), .words_o(semi_w), .excess_o(semi_excess)
  );

  rrn_ripple_step #(.XLEN(XLEN), .DBITS(DBITS)) u_step (
    .carry_i(run_c_q), .word_i(opnd[idx*XLEN +: XLEN]),
    .signed_top_i(sgn_q && last), .word_o(step_word), .carry_o(step_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SEMI;
      sgn_q   <= 1'b0;
      run_c_q <= '0;
      carry_q <= '0;
      for (int i = 0; i < NWORDS; i++) res_q[i] <= '0;
    end else if (go) begin
      mode_q  <= norm_mode_e'(mode_i);
      sgn_q   <= signed_i;
      run_c_q <= {1'b0, carry_in_i};
      if (norm_mode_e'(mode_i) == MODE_SEMI) begin
        for (int i = 0; i < NWORDS; i++) res_q[i] <= semi_w[i*XLEN +: XLEN];
        carry_q <= {{(DBITS+1){1'b0}}, semi_excess};
      end
    end else if (busy) begin
      res_q[idx] <= step_word;
      run_c_q    <= step_carry;
      if (last) carry_q <= step_carry;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_res
    assign res_flat[g*XLEN +: XLEN] = res_q[g];
  end

  assign busy_o    = busy;
  assign carry_o   = carry_q;
  assign rd_word_o = (int'(rd_idx_i) < NWORDS) ? res_q[rd_idx_i] : '0;

  // headroom summaries for the checks below
  logic semi_hi_any, full_red_any, lower_red_any;
  always_comb begin
    semi_hi_any   = 1'b0;
    full_red_any  = 1'b0;
    lower_red_any = 1'b0;
    for (int i = 0; i < NWORDS; i++) begin
      semi_hi_any  |= |res_q[i][XLEN-1:DBITS+1];
      full_red_any |= |res_q[i][XLEN-1:DBITS];
      if (i < NWORDS-1) lower_red_any |= |res_q[i][XLEN-1:DBITS];
    end
  end

  AST_SEMI_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q == MODE_SEMI) |-> !semi_hi_any); // R4
  AST_FULL_CANON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q == MODE_FULL) && !sgn_q |-> !full_red_any); // R7
  AST_SIGNED_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (mode_q == MODE_FULL) && sgn_q |-> !lower_red_any); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go && !busy |=> $stable(res_flat) && $stable(carry_q)); // R10
endmodule

// File: tb/rrn_carry_norm_tb.sv
`timescale 1ns/1ps
module rrn_carry_norm_tb;
  localparam int XLEN = 32, DBITS = 24, NWORDS = 4, IDXW = 2;
  localparam longint MASK = (64'd1 << DBITS) - 1;

  typedef struct packed {
    logic        full;
    logic        sgn;
    logic [31:0] cin;
    logic [127:0] w;   // word3..word0
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 32'h0,        {32'h0A000001, 32'h01FFFFFF, 32'hFF123456, 32'h12ABCDEF}},
    '{1'b0, 1'b0, 32'h5,        {4{32'hFFFFFFFF}}},
    '{1'b0, 1'b0, 32'hFFFFFFFF, 128'h0},
    '{1'b1, 1'b0, 32'h0,        {32'h00000001, 32'h00FFFFFF, 32'h00FFFFFF, 32'h01000000}},
    '{1'b1, 1'b0, 32'hFFFFFFFF, {4{32'hFFFFFFFF}}},
    '{1'b1, 1'b0, 32'h1,        {4{32'h00FFFFFF}}},
    '{1'b1, 1'b1, 32'h1,        {32'hFF000005, 32'h00FFFFFF, 32'h00FFFFFF, 32'h00FFFFFF}},
    '{1'b1, 1'b1, 32'h0,        {32'h00000010, 32'h00000000, 32'h00000003, 32'h7F000000}}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en = 1'b0, mode = 1'b0, sgn = 1'b0, start = 1'b0;
  logic [IDXW-1:0] ld_idx = '0, rd_idx = '0;
  logic [XLEN-1:0] ld_word = '0, cin = '0, rd_word;
  logic busy, done;
  logic [XLEN:0] carry;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  rrn_carry_norm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_word_i(ld_word),
    .mode_i(mode), .signed_i(sgn), .carry_in_i(cin), .start_i(start),
    .busy_o(busy), .done_o(done), .rd_idx_i(rd_idx), .rd_word_o(rd_word), .carry_o(carry)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input vec_t v, output logic [127:0] ew, output logic [32:0] ec);
    longint c, s;
    logic [31:0] x;
    ew = '0;
    if (!v.full) begin
      for (int i = 0; i < NWORDS; i++) begin
        x = v.w[i*32 +: 32];
        s = longint'(x) & MASK;
        if (i > 0) s += longint'(v.w[(i-1)*32 +: 32]) >> DBITS;
        ew[i*32 +: 32] = s[31:0];
      end
      ec = 33'(longint'(v.w[127:96]) >> DBITS);
    end else begin
      c = longint'(v.cin);
      for (int i = 0; i < NWORDS; i++) begin
        x = v.w[i*32 +: 32];
        if (v.sgn && i == NWORDS-1) begin
          s = c + longint'($signed(x));
          ew[i*32 +: 32] = s[31:0];
          c = s >>> DBITS;
        end else begin
          c = c + longint'(x);
          ew[i*32 +: 32] = 32'(c & MASK);
          c = c >> DBITS;
        end
      end
      ec = c[32:0];
    end
  endfunction

  task automatic load_vec(input logic [127:0] w);
    for (int i = 0; i < NWORDS; i++) begin
      ld_en = 1'b1; ld_idx = IDXW'(i); ld_word = w[i*32 +: 32];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  // start, optionally poisoning a load in the start cycle and a restart mid-pass
  task automatic run(input vec_t v, input bit poison, output int lat);
    mode = v.full; sgn = v.sgn; cin = v.cin; start = 1'b1;
    if (poison) begin ld_en = 1'b1; ld_idx = '0; ld_word = 32'hDEADBEEF; end
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    lat = 0;
    while (!done && lat < 50) begin
      if (poison && lat == 1) begin
        start = 1'b1; mode = ~v.full; ld_en = 1'b1; ld_idx = 2'd1; ld_word = 32'h0BADF00D;
      end
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0;
      lat++;
    end
  endtask

  task automatic check_res(input vec_t v, input string tag);
    logic [127:0] ew; logic [32:0] ec;
    model(v, ew, ec);
    for (int i = 0; i < NWORDS; i++) begin
      rd_idx = IDXW'(i); #1;
      chk(tag, 64'(rd_word), 64'(ew[i*32 +: 32]));
      if (!v.full) chk("R4 range", 64'(rd_word < 32'h01000100), 64'd1);
      else if (!v.sgn) chk("R7 canon", 64'(rd_word[31:24]), 64'd0);
    end
    chk(v.full ? (v.sgn ? "R8 carry" : "R5 carry") : "R4 excess", 64'(carry), 64'(ec));
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int lat;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 carry", 64'(carry), 0);
    for (int i = 0; i < NWORDS; i++) begin
      rd_idx = IDXW'(i); #1;
      chk("R1 word", 64'(rd_word), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      v = VECS[k];
      load_vec(v.w);
      run(v, 1'b0, lat);
      chk(v.full ? "R6 latency" : "R3 latency", 64'(lat), v.full ? 64'(NWORDS) : 64'd0);
      @(negedge clk);
      chk("R11 done pulse", 64'(done), 0);
      check_res(v, v.full ? (v.sgn ? "R8 word" : "R5 word") : "R3 word");
    end

    // R2 + R9: load in start cycle and restart/load mid-pass are dropped
    v = VECS[3];
    load_vec(v.w);
    run(v, 1'b1, lat);
    chk("R9 latency", 64'(lat), 64'(NWORDS));
    @(negedge clk);
    check_res(v, "R9 word");
    v.full = 1'b0;
    run(v, 1'b0, lat);
    @(negedge clk);
    check_res(v, "R2 word");

    // R10: results hold while operands change and no start
    load_vec(128'h11111111_22222222_33333333_44444444);
    repeat (3) @(negedge clk);
    check_res(v, "R10 word");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule